// File: doc/BRIEF.md
# Interrupt Acknowledge and Completion Unit

This block is the acknowledge and end-of-interrupt engine of one processor's interrupt interface. When the processor reads its acknowledge port, the unit takes the highest-pending interrupt offered by an external selector. If that interrupt's priority beats the priority currently running, the unit makes it the running interrupt, tells the pending store to drop it, and returns its ID. Otherwise it returns the spurious ID 1023.

Nested preemption is recorded as a linked chain. Each interrupt ID has a 10-bit link entry, and every successful acknowledge stores the interrupt it displaced in that entry. A completion of the running interrupt pops the chain. A completion of an interrupt deeper in the chain walks the links one hop per cycle and splices that interrupt out, raising `busy` while it does so. In the legacy build, a completed level-sensitive source that is still asserted is sent back to the pending store.

Top module: `iac_unit`

## Requirements
- R1: An acknowledge answers 1023 and leaves the running ID and running priority unchanged if any of these holds: the offered ID is 1023, the offered ID is at or above `NUM_IRQ`, or its priority (8-bit, lower value is more urgent) is not strictly below the running priority.
- R2: A successful acknowledge answers the offered ID on `ack_valid`, one cycle after `ack_req`. The running ID becomes that ID, and the running priority becomes that ID's table entry, read from bits [id*8 +: 8] of `prio_tbl`.
- R3: A successful acknowledge pulses `clr_valid` together with `ack_valid`, carrying the ID. `clr_mask` is all ones when the ID's `one_of_n` bit is 1; otherwise only bit `CPU_IDX` is set.
- R4: A completion whose ID is at or above `NUM_IRQ`, 1023 included, changes nothing.
- R5: A completion while the running ID is 1023 changes nothing and raises no re-pend.
- R6: Completing the running ID restores the linked previous ID as running, with that ID's table priority. When the restored ID is 1023, the running priority is 0x100.
- R7: Completing a non-running ID raises `busy` from the next cycle and follows the links from the running ID. When it finds the entry that points at the completed ID, it replaces that entry with the completed ID's own link. A later completion of the running ID then skips the removed ID.
- R8: A walk that reaches link 1023 without a match ends with the running ID, the running priority and the chain unchanged.
- R9: An acknowledge requested while `busy` is high answers 1023 and changes no state.
- R10: When `ack_req` and `eoi_req` arrive in the same cycle, the completion is processed and the acknowledge answers 1023.
- R11: With `LEGACY`=1, an accepted completion of an ID that is enabled, asserted, targeted at this CPU and level-sensitive (`edge_cfg` bit 0) pulses `repend_valid` with that ID one cycle later. In every other case `repend_valid` stays low.
- R12: A strictly more urgent interrupt can be acknowledged while another is running, so nesting reaches any depth, and each level is restored in turn on completion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hp_id | input | 10 | Highest-pending ID from the selector, 1023 for none |
| prio_tbl | input | NUM_IRQ*8 | Priority per ID, 8 bits each |
| one_of_n | input | NUM_IRQ | 1: acknowledge clears pending for all CPUs |
| edge_cfg | input | NUM_IRQ | 1: edge-sensitive, 0: level-sensitive |
| irq_en | input | NUM_IRQ | Enable per ID for this CPU |
| irq_level | input | NUM_IRQ | Input line state per ID for this CPU |
| irq_tgt | input | NUM_IRQ | ID is targeted at this CPU |
| ack_req | input | 1 | Acknowledge read strobe |
| eoi_req | input | 1 | Completion write strobe |
| eoi_id | input | 10 | ID written with the completion |
| busy | output | 1 | Chain walk in progress |
| ack_valid | output | 1 | Acknowledge answer valid |
| ack_id | output | 10 | Acknowledge answer |
| run_id | output | 10 | Running ID, 1023 when idle |
| run_prio | output | 9 | Running priority, 0x100 when idle |
| clr_valid | output | 1 | Pending-clear strobe |
| clr_id | output | 10 | ID to clear |
| clr_mask | output | NUM_CPU | CPUs whose pending bit is cleared |
| repend_valid | output | 1 | Set-pending strobe after completion |
| repend_id | output | 10 | ID to set pending again |

## Verification
Two functions can land in one cycle: a processor read of the acknowledge port and a completion write. They meet in two ways. The bench raises both strobes on the same clock edge, and it also issues an acknowledge in the cycle right after a completion has started a chain walk. In both cases it expects the acknowledge to answer 1023 with the running state untouched by it. It then judges the completion alone by the running ID and running priority it leaves behind, and by the chain order seen in later completions.

// File: rtl/iac_pkg.sv
`timescale 1ns/1ps
package iac_pkg;
    localparam int ID_W   = 10;
    localparam int PRIO_W = 8;

    typedef logic [ID_W-1:0]   irq_id_t;
    typedef logic [PRIO_W:0]   rprio_t;

    localparam irq_id_t NONE_ID   = irq_id_t'(1023);
    localparam rprio_t  IDLE_PRIO = rprio_t'(9'h100);

    typedef enum logic {ST_IDLE, ST_WALK} walk_state_t;

    function automatic logic id_is_none(input irq_id_t id);
        return id == NONE_ID;
    endfunction
endpackage

// File: rtl/iac_link_store.sv
`timescale 1ns/1ps
module iac_link_store
    import iac_pkg::*;
#(
    parameter int NUM_IRQ = 64
) (
    input  logic    clk,
    input  logic    rst,
    input  irq_id_t rd_a_addr,
    output irq_id_t rd_a_data,
    input  irq_id_t rd_b_addr,
    output irq_id_t rd_b_data,
    input  logic    wr_en,
    input  irq_id_t wr_addr,
    input  irq_id_t wr_data
);
    localparam int      IDX_W = $clog2(NUM_IRQ);
    localparam irq_id_t LIMIT = irq_id_t'(NUM_IRQ);

    irq_id_t link_q [NUM_IRQ];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NUM_IRQ; i++) link_q[i] <= NONE_ID;
        end else if (wr_en && wr_addr < LIMIT) begin
            link_q[wr_addr[IDX_W-1:0]] <= wr_data;
        end
    end

    always_comb begin
        rd_a_data = NONE_ID;
        rd_b_data = NONE_ID;
        if (rd_a_addr < LIMIT) rd_a_data = link_q[rd_a_addr[IDX_W-1:0]];
        if (rd_b_addr < LIMIT) rd_b_data = link_q[rd_b_addr[IDX_W-1:0]];
    end
endmodule

// File: rtl/iac_prio_mux.sv
`timescale 1ns/1ps
module iac_prio_mux
    import iac_pkg::*;
#(
    parameter int NUM_IRQ = 64
) (
    input  logic [NUM_IRQ*PRIO_W-1:0] tbl,
    input  irq_id_t                   id,
    output rprio_t                    prio
);
    localparam int      IDX_W = $clog2(NUM_IRQ);
    localparam irq_id_t LIMIT = irq_id_t'(NUM_IRQ);

    always_comb begin
        prio = IDLE_PRIO;
        if (id < LIMIT) prio = {1'b0, tbl[id[IDX_W-1:0]*PRIO_W +: PRIO_W]};
    end
endmodule

// File: rtl/iac_repend.sv
`timescale 1ns/1ps
module iac_repend
    import iac_pkg::*;
#(
    parameter int NUM_IRQ = 64,
    parameter bit LEGACY  = 1'b1
) (
    input  irq_id_t             id,
    input  logic [NUM_IRQ-1:0]  edge_cfg,
    input  logic [NUM_IRQ-1:0]  irq_en,
    input  logic [NUM_IRQ-1:0]  irq_level,
    input  logic [NUM_IRQ-1:0]  irq_tgt,
    output logic                hit
);
    localparam int      IDX_W = $clog2(NUM_IRQ);
    localparam irq_id_t LIMIT = irq_id_t'(NUM_IRQ);

    generate
        if (LEGACY) begin : g_legacy
            logic [IDX_W-1:0] idx;
            assign idx = id[IDX_W-1:0];
            assign hit = (id < LIMIT) && !edge_cfg[idx] && irq_en[idx]
                         && irq_level[idx] && irq_tgt[idx];
        end else begin : g_modern
            assign hit = 1'b0;
        end
    endgenerate
endmodule

// File: rtl/iac_unit.sv
`timescale 1ns/1ps
module iac_unit
    import iac_pkg::*;
#(
    parameter int NUM_IRQ = 64,
    parameter int NUM_CPU = 4,
    parameter int CPU_IDX = 1,
    parameter bit LEGACY  = 1'b1
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic [9:0]                hp_id,
    input  logic [NUM_IRQ*8-1:0]      prio_tbl,
    input  logic [NUM_IRQ-1:0]        one_of_n,
    input  logic [NUM_IRQ-1:0]        edge_cfg,
    input  logic [NUM_IRQ-1:0]        irq_en,
    input  logic [NUM_IRQ-1:0]        irq_level,
    input  logic [NUM_IRQ-1:0]        irq_tgt,
    input  logic                      ack_req,
    input  logic                      eoi_req,
    input  logic [9:0]                eoi_id,
    output logic                      busy,
    output logic                      ack_valid,
    output logic [9:0]                ack_id,
    output logic [9:0]                run_id,
    output logic [8:0]                run_prio,
    output logic                      clr_valid,
    output logic [9:0]                clr_id,
    output logic [NUM_CPU-1:0]        clr_mask,
    output logic                      repend_valid,
    output logic [9:0]                repend_id
);
    localparam int      IDX_W = $clog2(NUM_IRQ);
    localparam irq_id_t LIMIT = irq_id_t'(NUM_IRQ);
    localparam logic [NUM_CPU-1:0] OWN_MASK = NUM_CPU'(1) << CPU_IDX;

    walk_state_t st_q;
    irq_id_t     run_id_q, cur_q, tgt_q;
    rprio_t      run_prio_q;

    irq_id_t link_a_addr, link_a, link_b;
    rprio_t  hp_prio, rs_prio;
    logic    rp_hit, eoi_ok, ack_ok, walk_hit, walk_end, link_we;
    irq_id_t link_wa, link_wd;

    assign link_a_addr = (st_q == ST_WALK) ? cur_q : run_id_q;

    iac_link_store #(.NUM_IRQ(NUM_IRQ)) u_links (
        .clk(clk), .rst(rst),
        .rd_a_addr(link_a_addr), .rd_a_data(link_a),
        .rd_b_addr(tgt_q),       .rd_b_data(link_b),
        .wr_en(link_we), .wr_addr(link_wa), .wr_data(link_wd)
    );

    iac_prio_mux #(.NUM_IRQ(NUM_IRQ)) u_prio_hp (
        .tbl(prio_tbl), .id(hp_id), .prio(hp_prio)
    );

    iac_prio_mux #(.NUM_IRQ(NUM_IRQ)) u_prio_rs (
        .tbl(prio_tbl), .id(link_a), .prio(rs_prio)
    );

    iac_repend #(.NUM_IRQ(NUM_IRQ), .LEGACY(LEGACY)) u_repend (
        .id(eoi_id), .edge_cfg(edge_cfg), .irq_en(irq_en),
        .irq_level(irq_level), .irq_tgt(irq_tgt), .hit(rp_hit)
    );

    // Completion wins over a same-cycle acknowledge; a walk blocks both.
    assign eoi_ok   = (st_q == ST_IDLE) && eoi_req && (eoi_id < LIMIT)
                      && !id_is_none(run_id_q);
    assign ack_ok   = (st_q == ST_IDLE) && ack_req && !eoi_req
                      && (hp_prio < run_prio_q);
    assign walk_hit = (st_q == ST_WALK) && (link_a == tgt_q);
    assign walk_end = (st_q == ST_WALK) && (walk_hit || id_is_none(link_a));

    assign link_we = ack_ok || walk_hit;
    assign link_wa = ack_ok ? hp_id : cur_q;
    assign link_wd = ack_ok ? run_id_q : link_b;

    logic model_all;
    assign model_all = (hp_id < LIMIT) && one_of_n[hp_id[IDX_W-1:0]];

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q         <= ST_IDLE;
            run_id_q     <= NONE_ID;
            run_prio_q   <= IDLE_PRIO;
            cur_q        <= NONE_ID;
            tgt_q        <= NONE_ID;
            ack_valid    <= 1'b0;
            ack_id       <= NONE_ID;
            clr_valid    <= 1'b0;
            clr_id       <= NONE_ID;
            clr_mask     <= '0;
            repend_valid <= 1'b0;
            repend_id    <= NONE_ID;
        end else begin
            ack_valid    <= ack_req;
            ack_id       <= ack_ok ? hp_id : NONE_ID;
            clr_valid    <= ack_ok;
            clr_id       <= hp_id;
            clr_mask     <= model_all ? '1 : OWN_MASK;
            repend_valid <= eoi_ok && rp_hit;
            repend_id    <= eoi_id;
            case (st_q)
                ST_IDLE: begin
                    if (eoi_ok) begin
                        if (eoi_id == run_id_q) begin
                            run_id_q   <= link_a;
                            run_prio_q <= rs_prio;
                        end else begin
                            st_q  <= ST_WALK;
                            cur_q <= run_id_q;
                            tgt_q <= eoi_id;
                        end
                    end else if (ack_ok) begin
                        run_id_q   <= hp_id;
                        run_prio_q <= hp_prio;
                    end
                end
                ST_WALK: begin
                    if (walk_end) st_q <= ST_IDLE;
                    else          cur_q <= link_a;
                end
                default: st_q <= ST_IDLE;
            endcase
        end
    end

    assign busy     = (st_q == ST_WALK);
    assign run_id   = run_id_q;
    assign run_prio = run_prio_q;

    AST_ACK_REFUSED_KEEPS: assert property (@(posedge clk) disable iff (rst)
        (ack_req && !eoi_req && !busy && hp_prio >= run_prio_q)
        |=> ($stable(run_id) && ack_id == NONE_ID)); // R1
    AST_ACK_BECOMES_RUN: assert property (@(posedge clk) disable iff (rst)
        (ack_valid && ack_id != NONE_ID) |-> (run_id == ack_id)); // R2
    AST_CLR_PAIRS_ACK: assert property (@(posedge clk) disable iff (rst)
        clr_valid |-> (ack_valid && clr_id == ack_id && clr_mask != '0)); // R3
    AST_EOI_RANGE_IGNORED: assert property (@(posedge clk) disable iff (rst)
        (eoi_req && !busy && eoi_id >= LIMIT)
        |=> ($stable(run_id) && !busy && !repend_valid)); // R4
    AST_IDLE_PRIO: assert property (@(posedge clk) disable iff (rst)
        (run_id == NONE_ID) |-> (run_prio == IDLE_PRIO)); // R6
    AST_BUSY_REFUSES_ACK: assert property (@(posedge clk) disable iff (rst)
        (busy && ack_req) |=> (ack_id == NONE_ID && !clr_valid)); // R9
    AST_SAME_CYCLE_EOI_WINS: assert property (@(posedge clk) disable iff (rst)
        (ack_req && eoi_req) |=> (ack_id == NONE_ID)); // R10
    AST_WALK_HOLDS_RUN: assert property (@(posedge clk) disable iff (rst)
        busy |=> $stable(run_id)); // R7
endmodule

// File: tb/sim_iac_unit.sv
`timescale 1ns/1ps
module sim_iac_unit;
    localparam int NUM_IRQ = 64;
    localparam int NUM_CPU = 4;
    localparam int CPU_IDX = 1;
    localparam int NONE    = 1023;

    logic                   clk = 1'b0;
    logic                   rst = 1'b1;
    logic [9:0]             hp_id = 10'd1023;
    logic [NUM_IRQ*8-1:0]   prio_tbl;
    logic [NUM_IRQ-1:0]     one_of_n = '0;
    logic [NUM_IRQ-1:0]     edge_cfg = '1;
    logic [NUM_IRQ-1:0]     irq_en = '0;
    logic [NUM_IRQ-1:0]     irq_level = '0;
    logic [NUM_IRQ-1:0]     irq_tgt = '0;
    logic                   ack_req = 1'b0;
    logic                   eoi_req = 1'b0;
    logic [9:0]             eoi_id = '0;
    logic                   busy, ack_valid, clr_valid, repend_valid;
    logic [9:0]             ack_id, run_id, clr_id, repend_id;
    logic [8:0]             run_prio;
    logic [NUM_CPU-1:0]     clr_mask;

    int checks = 0;
    int errors = 0;
    logic rp_seen;
    logic [9:0] rp_id_seen;

    always #2.5 clk = ~clk;

    iac_unit #(.NUM_IRQ(NUM_IRQ), .NUM_CPU(NUM_CPU), .CPU_IDX(CPU_IDX), .LEGACY(1'b1)) u0 (
        .clk(clk), .rst(rst), .hp_id(hp_id), .prio_tbl(prio_tbl),
        .one_of_n(one_of_n), .edge_cfg(edge_cfg), .irq_en(irq_en),
        .irq_level(irq_level), .irq_tgt(irq_tgt), .ack_req(ack_req),
        .eoi_req(eoi_req), .eoi_id(eoi_id), .busy(busy),
        .ack_valid(ack_valid), .ack_id(ack_id), .run_id(run_id),
        .run_prio(run_prio), .clr_valid(clr_valid), .clr_id(clr_id),
        .clr_mask(clr_mask), .repend_valid(repend_valid), .repend_id(repend_id)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic set_prio(input int id, input int p);
        prio_tbl[id*8 +: 8] = p[7:0];
    endtask

    task automatic ack_op(input int hp);
        @(negedge clk);
        hp_id = hp[9:0];
        ack_req = 1'b1;
        @(negedge clk);
        ack_req = 1'b0;
    endtask

    task automatic eoi_op(input int id);
        @(negedge clk);
        eoi_id = id[9:0];
        eoi_req = 1'b1;
        @(negedge clk);
        eoi_req = 1'b0;
        rp_seen = repend_valid;
        rp_id_seen = repend_id;
        while (busy) @(negedge clk);
    endtask

    task automatic t_reset;
        chk(run_id == 10'(NONE), "R6 reset run_id", run_id, NONE);
        chk(run_prio == 9'h100, "R6 reset run_prio", run_prio, 256);
        chk(!busy && !ack_valid, "R9 reset busy/ack_valid", {busy, ack_valid}, 0);
    endtask

    task automatic t_refused;
        ack_op(NONE);
        chk(ack_valid && ack_id == 10'(NONE), "R1 none offered", ack_id, NONE);
        chk(run_id == 10'(NONE) && !clr_valid, "R1 no state change", run_id, NONE);
        ack_op(64);
        chk(ack_id == 10'(NONE), "R1 out-of-range offered", ack_id, NONE);
    endtask

    task automatic t_nest;
        ack_op(40);
        chk(ack_id == 10'd40, "R2 ack id", ack_id, 40);
        chk(run_id == 10'd40 && run_prio == 9'h80, "R2 run prio", run_prio, 128);
        chk(clr_valid && clr_id == 10'd40 && clr_mask == 4'b0010, "R3 own mask", clr_mask, 2);
        ack_op(41);
        chk(ack_id == 10'(NONE) && run_id == 10'd40, "R1 equal priority refused", ack_id, NONE);
        ack_op(35);
        chk(ack_id == 10'd35 && run_prio == 9'h40, "R12 preempt", ack_id, 35);
        chk(clr_mask == 4'hF, "R3 all-CPU mask", clr_mask, 15);
        ack_op(20);
        chk(run_id == 10'd20 && run_prio == 9'h10, "R12 third level", run_id, 20);
    endtask

    task automatic t_splice;
        @(negedge clk);
        eoi_id = 10'd35;
        eoi_req = 1'b1;
        @(negedge clk);
        eoi_req = 1'b0;
        chk(busy, "R7 busy during walk", busy, 1);
        while (busy) @(negedge clk);
        chk(run_id == 10'd20, "R7 running kept", run_id, 20);
        eoi_op(20);
        chk(run_id == 10'd40 && run_prio == 9'h80, "R7 spliced chain", run_id, 40);
        chk(!rp_seen, "R11 no repend edge src", rp_seen, 0);
        eoi_op(50);
        chk(run_id == 10'd40 && run_prio == 9'h80, "R8 not found", run_id, 40);
    endtask

    task automatic t_ignored_and_repend;
        eoi_op(64);
        chk(run_id == 10'd40 && !rp_seen, "R4 id=NUM_IRQ ignored", run_id, 40);
        eoi_op(NONE);
        chk(run_id == 10'd40, "R4 1023 ignored", run_id, 40);
        edge_cfg[40] = 1'b0; irq_en[40] = 1'b1; irq_level[40] = 1'b1; irq_tgt[40] = 1'b1;
        eoi_op(40);
        chk(rp_seen && rp_id_seen == 10'd40, "R11 repend", rp_id_seen, 40);
        chk(run_id == 10'(NONE) && run_prio == 9'h100, "R6 idle restore", run_prio, 256);
        eoi_op(40);
        chk(!rp_seen && run_id == 10'(NONE), "R5 idle ignored", rp_seen, 0);
    endtask

    task automatic t_busy_ack;
        ack_op(40);
        ack_op(35);
        @(negedge clk);
        eoi_id = 10'd40;
        eoi_req = 1'b1;
        @(negedge clk);
        eoi_req = 1'b0;
        chk(busy, "R9 walk started", busy, 1);
        hp_id = 10'd20;
        ack_req = 1'b1;
        @(negedge clk);
        ack_req = 1'b0;
        chk(ack_valid && ack_id == 10'(NONE), "R9 ack during busy", ack_id, NONE);
        while (busy) @(negedge clk);
        chk(run_id == 10'd35 && run_prio == 9'h40, "R9 state unchanged", run_id, 35);
    endtask

    task automatic t_same_cycle;
        @(negedge clk);
        hp_id = 10'd20;
        ack_req = 1'b1;
        eoi_id = 10'd35;
        eoi_req = 1'b1;
        @(negedge clk);
        ack_req = 1'b0;
        eoi_req = 1'b0;
        chk(ack_valid && ack_id == 10'(NONE), "R10 ack refused", ack_id, NONE);
        chk(run_id == 10'(NONE), "R10 completion done", run_id, NONE);
    endtask

    initial begin
        prio_tbl = '1;
        for (int i = 0; i < NUM_IRQ; i++) set_prio(i, 8'hC0);
        set_prio(40, 8'h80); set_prio(41, 8'h80);
        set_prio(35, 8'h40); set_prio(20, 8'h10);
        one_of_n[35] = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_refused();
        t_nest();
        t_splice();
        t_ignored_and_repend();
        t_busy_ack();
        t_same_cycle();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #200000;
        errors++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule